// File: doc/BRIEF.md
# Iterative 64-bit Substitution-Permutation Encryption Core

This block encrypts one 64-bit block with a substitution-permutation cipher of 31 identical rounds. It computes one round per clock. A start pulse loads the plaintext. From then on the core shows, on an index output, which round key it needs. The key source outside the block must answer on the key input within the same cycle. The key schedule itself is not part of the block. After the last round, one more key is XORed in as post-whitening. The ciphertext is then latched and a one-cycle done pulse is raised.

The 64-bit state is treated as sixteen 4-bit nibbles. Nibble k occupies bits 4k+3 down to 4k, and bit 4k+3 is the most significant. A round first XORs the 64-bit round key into the state. It then replaces every nibble through a fixed 4-bit substitution and finally moves the state bits to new positions with a fixed permutation. A complete operation takes 32 cycles: 31 rounds and one whitening cycle. A new start is accepted as soon as the core is idle again.

Top module: `spn64_core`

## Requirements
- R1: While rst_n is low at a rising clock edge, the core returns to idle: after that edge busy_o=0, done_o=0, rnd_idx_o=0 and ctext_o=0. This holds even when an operation was in progress.
- R2: A start_i high at an edge where busy_o is low loads ptext_i into the state. After that edge busy_o=1 and rnd_idx_o=1.
- R3: While busy, rnd_idx_o steps by one per clock from 1 to 32. In each cycle the core uses the rkey_i value present in that cycle as the key for the shown index: indices 1 to 31 are the round keys and index 32 is the whitening key. When idle, rnd_idx_o is 0.
- R4: One round maps state s to P(S(s XOR k)). S replaces every nibble by the table, for inputs 0 to F in order: C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. P moves bit i to bit (16*i) mod 63 for i from 0 to 62 and leaves bit 63 in place.
- R5: Exactly 31 rounds are applied. The ciphertext is then the state after round 31 XORed with the key supplied at index 32.
- R6: done_o rises on the 32nd rising edge after the edge that accepted start and stays high for exactly one cycle. busy_o falls on that same edge.
- R7: A start_i pulse while busy_o is high has no effect: the index sequence, the timing of done_o and the ciphertext are those of the run already in progress.
- R8: ctext_o changes only on the edge that raises done_o. It keeps its value afterwards, through idle cycles and through the whole of the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only when idle |
| ptext_i | input | 64 | Plaintext, sampled on the accepting edge |
| rkey_i | input | 64 | Key for the round shown on rnd_idx_o, same cycle |
| rnd_idx_o | output | 6 | Requested key index, 1 to 32 while busy, 0 when idle |
| busy_o | output | 1 | High while an operation runs |
| done_o | output | 1 | One-cycle pulse when ctext_o has been updated |
| ctext_o | output | 64 | Ciphertext of the last completed operation |

## Verification
The assertions rely on three conditions. Reset is held for at least one rising edge before use. rkey_i is a combinational answer to rnd_idx_o that is settled by the end of each cycle. start_i may arrive at any time, including mid-operation and on the final whitening cycle. The bench drives all inputs on falling edges. Its key source is a table indexed directly by rnd_idx_o, so every key arrives in the cycle it is requested. It also injects start pulses at the middle and at the last index of a run, which covers the cases where the core must ignore them.

// File: rtl/spn64_pkg.sv
// Package: shared constants and the two fixed mappings of the cipher.
// Assumes a 64-bit state split into 4-bit nibbles, nibble k at bits 4k+3:4k.
package spn64_pkg;

    localparam int BLOCK_W = 64;
    localparam int NIB_W   = 4;
    localparam int NIBBLES = BLOCK_W / NIB_W;

    // Substitute one nibble through the fixed 4-bit mapping.
    function automatic logic [NIB_W-1:0] sbox4(input logic [NIB_W-1:0] x);
        logic [NIB_W-1:0] y;
        case (x)
            4'h0: y = 4'hC;  4'h1: y = 4'h5;  4'h2: y = 4'h6;  4'h3: y = 4'hB;
            4'h4: y = 4'h9;  4'h5: y = 4'h0;  4'h6: y = 4'hA;  4'h7: y = 4'hD;
            4'h8: y = 4'h3;  4'h9: y = 4'hE;  4'hA: y = 4'hF;  4'hB: y = 4'h8;
            4'hC: y = 4'h4;  4'hD: y = 4'h7;  4'hE: y = 4'h1;  default: y = 4'h2;
        endcase
        return y;
    endfunction

    // Destination bit of source bit b in the permutation layer.
    function automatic int perm_dst(input int b);
        if (b == BLOCK_W - 1) return b;
        return (b * NIBBLES) % (BLOCK_W - 1);
    endfunction

endpackage

// File: rtl/spn64_sbox_layer.sv
// Substitution layer: sixteen copies of the 4-bit mapping, one per nibble.
// Purely combinational; assumes nibble k sits at bits 4k+3:4k.
module spn64_sbox_layer
    import spn64_pkg::*;
(
    input  logic [BLOCK_W-1:0] din_i,
    output logic [BLOCK_W-1:0] dout_o
);

    // One substitution box per nibble position.
    for (genvar n = 0; n < NIBBLES; n++) begin : g_nib
        assign dout_o[n*NIB_W +: NIB_W] = sbox4(din_i[n*NIB_W +: NIB_W]);
    end

endmodule

// File: rtl/spn64_perm_layer.sv
// Permutation layer: fixed wiring that moves every state bit to its
// destination; no logic gates, only routing.
module spn64_perm_layer
    import spn64_pkg::*;
(
    input  logic [BLOCK_W-1:0] din_i,
    output logic [BLOCK_W-1:0] dout_o
);

    // Route each source bit to its computed destination.
    for (genvar b = 0; b < BLOCK_W; b++) begin : g_bit
        localparam int DST = perm_dst(b);
        assign dout_o[DST] = din_i[b];
    end

endmodule

// File: rtl/spn64_round.sv
// One full round: key mixing, substitution, permutation.
// Combinational; the caller registers the result once per clock.
module spn64_round
    import spn64_pkg::*;
(
    input  logic [BLOCK_W-1:0] state_i,
    input  logic [BLOCK_W-1:0] key_i,
    output logic [BLOCK_W-1:0] state_o
);

    logic [BLOCK_W-1:0] mixed;
    logic [BLOCK_W-1:0] subst;

    // Key mixing ahead of the substitution layer.
    assign mixed = state_i ^ key_i;

    spn64_sbox_layer u_sbox (
        .din_i  (mixed),
        .dout_o (subst)
    );

    spn64_perm_layer u_perm (
        .din_i  (subst),
        .dout_o (state_o)
    );

endmodule

// File: rtl/spn64_seq.sv
// Sequencer: tracks the key index of the running operation, accepts start
// only when idle and raises a one-cycle done pulse after the whitening step.
// Assumes synchronous active-low reset held for at least one edge.
module spn64_seq #(
    parameter  int NUM_ROUNDS = 31,
    localparam int IDX_W      = $clog2(NUM_ROUNDS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             load_o,
    output logic             step_o,
    output logic             fin_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] LAST_RND = IDX_W'(NUM_ROUNDS);
    localparam logic [IDX_W-1:0] WHT_IDX  = IDX_W'(NUM_ROUNDS + 1);

    logic             busy_q;
    logic             done_q;
    logic [IDX_W-1:0] idx_q;

    // Decode the current cycle's action from the state.
    assign load_o = start_i && !busy_q;
    assign step_o = busy_q && (idx_q <= LAST_RND);
    assign fin_o  = busy_q && (idx_q == WHT_IDX);

    // Advance the index and busy flag; register the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            done_q <= fin_o;
            if (load_o) begin
                busy_q <= 1'b1;
                idx_q  <= IDX_W'(1);
            end else if (fin_o) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else if (busy_q) begin
                idx_q  <= idx_q + IDX_W'(1);
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign idx_o  = idx_q;

    AST_LOAD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && idx_o == IDX_W'(1))); // R2
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && idx_o != WHT_IDX) |=> (busy_o && idx_o == $past(idx_o) + IDX_W'(1))); // R3
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (idx_o >= IDX_W'(1) && idx_o <= WHT_IDX)); // R3
    AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (idx_o == '0)); // R3
    AST_LAST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && idx_o == WHT_IDX) |=> (done_o && !busy_o)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && idx_o != WHT_IDX) |=> (busy_o && idx_o == $past(idx_o) + IDX_W'(1))); // R7

endmodule

// File: rtl/spn64_core.sv
// Top: iterative 64-bit substitution-permutation encryption core.
// One round per clock, then a whitening cycle; round keys are requested
// through rnd_idx_o and must be answered on rkey_i in the same cycle.
module spn64_core
    import spn64_pkg::*;
#(
    parameter  int NUM_ROUNDS = 31,
    localparam int IDX_W      = $clog2(NUM_ROUNDS + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [BLOCK_W-1:0] ptext_i,
    input  logic [BLOCK_W-1:0] rkey_i,
    output logic [IDX_W-1:0]   rnd_idx_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [BLOCK_W-1:0] ctext_o
);

    logic               load;
    logic               step;
    logic               fin;
    logic [BLOCK_W-1:0] state_q;
    logic [BLOCK_W-1:0] round_out;
    logic [BLOCK_W-1:0] ctext_q;

    spn64_seq #(.NUM_ROUNDS(NUM_ROUNDS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .fin_o   (fin),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .idx_o   (rnd_idx_o)
    );

    spn64_round u_round (
        .state_i (state_q),
        .key_i   (rkey_i),
        .state_o (round_out)
    );

    // Hold the cipher state: load plaintext, then one round per clock.
    always_ff @(posedge clk) begin
        if (!rst_n)    state_q <= '0;
        else if (load) state_q <= ptext_i;
        else if (step) state_q <= round_out;
    end

    // Capture the whitened result once, on the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   ctext_q <= '0;
        else if (fin) ctext_q <= state_q ^ rkey_i;
    end

    assign ctext_o = ctext_q;

    AST_STATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (state_q == $past(ptext_i))); // R2
    AST_CT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(ctext_o)); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R6

endmodule

// File: tb/spn64_core_test.sv
`timescale 1ns/1ps
module spn64_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] ptext = '0;
    logic [63:0] rkey;
    logic [5:0]  idx;
    logic        busy;
    logic        done;
    logic [63:0] ctext;
    logic [63:0] rk_tab [0:32];
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    // Key source: answers the requested index within the same cycle.
    assign rkey = (idx <= 6'd32) ? rk_tab[idx] : 64'h0;

    spn64_core uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ptext_i(ptext),
        .rkey_i(rkey), .rnd_idx_o(idx), .busy_o(busy), .done_o(done),
        .ctext_o(ctext)
    );

    function automatic logic [3:0] m_sub(input logic [3:0] x);
        logic [3:0] t [16] = '{4'hC,4'h5,4'h6,4'hB,4'h9,4'h0,4'hA,4'hD,
                               4'h3,4'hE,4'hF,4'h8,4'h4,4'h7,4'h1,4'h2};
        return t[x];
    endfunction

    function automatic logic [63:0] m_round(input logic [63:0] s, input logic [63:0] k);
        logic [63:0] a, b;
        a = s ^ k;
        for (int n = 0; n < 16; n++) a[n*4 +: 4] = m_sub(a[n*4 +: 4]);
        b = '0;
        for (int i = 0; i < 64; i++) b[(i == 63) ? 63 : (i * 16) % 63] = a[i];
        return b;
    endfunction

    function automatic logic [63:0] m_encrypt(input logic [63:0] pt);
        logic [63:0] s;
        s = pt;
        for (int r = 1; r <= 31; r++) s = m_round(s, rk_tab[r]);
        return s ^ rk_tab[32];
    endfunction

    // Fill the key table from an 80-bit master key (standard schedule).
    task automatic sched80(input logic [79:0] key);
        logic [79:0] k;
        k = key;
        for (int r = 1; r <= 32; r++) begin
            rk_tab[r] = k[79:16];
            k = {k[18:0], k[79:19]};
            k[79:76] = m_sub(k[79:76]);
            k[19:15] = k[19:15] ^ 5'(r);
        end
    endtask

    task automatic sched_arbitrary(input logic [63:0] seed);
        logic [63:0] v;
        v = seed;
        for (int r = 1; r <= 32; r++) begin
            v = v * 64'h5851F42D4C957F2D + 64'(r);
            rk_tab[r] = v;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Run one operation; checks R2/R3/R6, optional busy start (R7) and hold (R8).
    task automatic run_block(input logic [63:0] pt, input int inject_at,
                             input logic [63:0] inject_pt, input bit hold_chk,
                             input logic [63:0] hold_val, output logic [63:0] result);
        int done_cyc;
        @(negedge clk);
        start = 1'b1;
        ptext = pt;
        @(negedge clk);
        start = 1'b0;
        ptext = 64'hA5A5_5A5A_0F0F_F0F0;
        chk(busy && idx == 6'd1, "R2 load", {58'b0, idx}, 64'd1);
        done_cyc = 0;
        for (int c = 1; c <= 40; c++) begin
            if (c > 1) @(negedge clk);
            start = 1'b0;
            if (done) begin
                done_cyc = c;
                break;
            end
            if (c <= 32) chk(busy && idx == 6'(c), "R3 index", {58'b0, idx}, 64'(c));
            if (hold_chk && c == 16) chk(ctext == hold_val, "R8 hold during run", ctext, hold_val);
            if (inject_at == c) begin
                start = 1'b1;
                ptext = inject_pt;
            end
        end
        chk(done_cyc == 33, "R6 latency", 64'(done_cyc), 64'd33);
        chk(!busy, "R6 busy falls with done", {63'b0, busy}, 64'd0);
        result = ctext;
        @(negedge clk);
        chk(!done, "R6 single-cycle done", {63'b0, done}, 64'd0);
    endtask

    task automatic t_reset();
        logic [63:0] r;
        start = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && idx == 0 && ctext == 0, "R1 reset state",
            {ctext[31:0], 22'b0, busy, done, 2'b0, idx}, 64'd0);
        // Reset in the middle of an operation.
        sched_arbitrary(64'h1);
        start = 1'b1;
        ptext = 64'h1234;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(!busy && idx == 0 && !done, "R1 mid-run reset", {57'b0, busy, idx}, 64'd0);
        r = ctext;
        chk(r == 64'h0, "R1 ciphertext cleared", r, 64'h0);
    endtask

    task automatic t_known(input logic [79:0] key, input logic [63:0] pt, input logic [63:0] exp);
        logic [63:0] r;
        sched80(key);
        run_block(pt, 0, '0, 1'b0, '0, r);
        chk(r == exp, "R4 R5 known answer", r, exp);
        chk(r == m_encrypt(pt), "R4 model agreement", r, m_encrypt(pt));
    endtask

    task automatic t_arbitrary(input logic [63:0] seed, input logic [63:0] pt);
        logic [63:0] r;
        sched_arbitrary(seed);
        run_block(pt, 0, '0, 1'b0, '0, r);
        chk(r == m_encrypt(pt), "R4 arbitrary keys", r, m_encrypt(pt));
    endtask

    task automatic t_whitening();
        logic [63:0] c0, c1;
        logic [63:0] x;
        x = 64'h0123_4567_89AB_CDEF;
        for (int r = 0; r <= 32; r++) rk_tab[r] = '0;
        run_block(64'hFEDC_BA98_7654_3210, 0, '0, 1'b0, '0, c0);
        chk(c0 == m_encrypt(64'hFEDC_BA98_7654_3210), "R5 zero keys", c0, m_encrypt(64'hFEDC_BA98_7654_3210));
        rk_tab[32] = x;
        run_block(64'hFEDC_BA98_7654_3210, 0, '0, 1'b0, '0, c1);
        chk((c0 ^ c1) == x, "R5 whitening key only at index 32", c0 ^ c1, x);
    endtask

    task automatic t_busy_start(input int at);
        logic [63:0] r;
        sched_arbitrary(64'h77);
        run_block(64'h0BAD_CAFE_1234_5678, at, 64'hFFFF_0000_FFFF_0000, 1'b0, '0, r);
        chk(r == m_encrypt(64'h0BAD_CAFE_1234_5678), "R7 start while busy ignored", r,
            m_encrypt(64'h0BAD_CAFE_1234_5678));
        chk(!busy && idx == 0, "R7 no second run", {57'b0, busy, idx}, 64'd0);
    endtask

    task automatic t_hold();
        logic [63:0] first, second;
        sched_arbitrary(64'h99);
        run_block(64'h1111_2222_3333_4444, 0, '0, 1'b0, '0, first);
        repeat (6) @(negedge clk);
        chk(ctext == first && !done, "R8 hold while idle", ctext, first);
        run_block(64'h5555_6666_7777_8888, 0, '0, 1'b1, first, second);
        chk(second == m_encrypt(64'h5555_6666_7777_8888), "R8 next result", second,
            m_encrypt(64'h5555_6666_7777_8888));
    endtask

    initial begin
        rk_tab[0] = '0;
        t_reset();
        t_known(80'h0, 64'h0, 64'h5579C1387B228445);
        t_known({80{1'b1}}, 64'h0, 64'hE72C46C0F5945049);
        t_known(80'h0, {64{1'b1}}, 64'hA112FFC72F68417B);
        t_known({80{1'b1}}, {64{1'b1}}, 64'h3333DCD3213210D2);
        t_arbitrary(64'h3C, 64'hDEAD_BEEF_0000_FFFF);
        t_arbitrary(64'hC3, 64'h8000_0000_0000_0001);
        t_whitening();
        t_busy_start(10);
        t_busy_start(32);
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule